// File: doc/BRIEF.md
# Load Value Replication Queue

This block passes load results from a leading execution thread to a trailing, redundant thread. The two roles are fixed when the block is built. Only the leading thread's loads reach the data cache. When one of its loads commits, the committed address and the returned value are pushed into the queue. A load of the leading thread that is squashed never commits, so its result never enters the queue.

The trailing thread runs in program order and never touches the cache. Each of its loads takes the oldest entry in the queue as its value. The address the trailing thread computed is compared with the stored address, and a difference is reported as a fault. External writes that land between the two threads' accesses cannot change what the trailing thread sees, so they cannot raise a false fault. Cache pairing between the threads is not needed.

Occupancy is tracked by a three-state machine: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. The transitions are:
- `ST_EMPTY` to `ST_PARTIAL` on a push.
- `ST_PARTIAL` to `ST_FULL` on a push with no pop while one slot is left.
- `ST_PARTIAL` to `ST_EMPTY` on a pop with no push while one entry is left.
- `ST_FULL` to `ST_PARTIAL` on a pop.

In every other case the state holds.

Top module: `load_replay_queue`

## Requirements
- R1: After reset the queue is empty. `lead_ready` is 1, `trail_avail` is 0, `trail_mismatch` is 0 and `fault_flag` is 0.
- R2: A push takes place on a rising edge where `lead_valid` and `lead_ready` are both 1. It appends the pair (`lead_addr`, `lead_data`) to the queue.
- R3: While `trail_avail` is 1, `trail_data` shows the data of the oldest entry not yet consumed. An edge with `trail_valid` and `trail_avail` both 1 consumes that entry, so entries leave in the order they were pushed.
- R4: `trail_avail` is 0 exactly when the queue holds no entry. A `trail_valid` request in that state stalls and consumes nothing.
- R5: With DEPTH entries held, `lead_ready` is 0. A `lead_valid` on such an edge is ignored and stores nothing.
- R6: On an edge with both a push and a pop, the occupancy is unchanged.
- R7: `trail_mismatch` is 1 in the same cycle in which `trail_valid` and `trail_avail` are 1 and `trail_addr` differs from the stored address of the oldest entry. `fault_flag` becomes 1 on the following edge and stays 1 until reset.
- R8: `trail_mismatch` stays 0 when the trailing address equals the stored address, and whenever no entry is consumed.
- R9: After a pop from a full queue, `lead_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading thread commits a load |
| lead_addr | input | AW | Committed load address |
| lead_data | input | DW | Committed load value |
| lead_ready | output | 1 | Queue can accept a commit |
| trail_valid | input | 1 | Trailing thread requests its next load value |
| trail_addr | input | AW | Address computed by the trailing load |
| trail_avail | output | 1 | An entry is ready for the trailing thread |
| trail_data | output | DW | Value for the trailing load |
| trail_mismatch | output | 1 | Address disagreement on the current consume |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
The bench builds the block with DEPTH 4, AW 8 and DW 16. The small depth means the queue reaches full and wraps its pointers within a few cycles. It then sweeps every 4-cycle pattern of push and pop requests (256 sequences) from many starting occupancies. Every empty, full and simultaneous push-and-pop transition is therefore reached repeatedly, and each cycle is checked against an arithmetic queue model. A final phase injects address disagreements, checks that the fault flag stays set, and then resets the block.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/lrq_store.sv
module lrq_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PW'(g))) begin
                addr_mem[g] <= wr_addr;
                data_mem[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_addr = addr_mem[rd_ptr];
        rd_data = data_mem[rd_ptr];
    end
endmodule

// File: rtl/lrq_ctrl.sv
module lrq_ctrl
    import lrq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          ready,
    output logic          avail,
    output logic          push,
    output logic          pop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr
);
    occ_state_t    state, state_nxt;
    logic [CW-1:0] count;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // next state and outputs
    always_comb begin
        ready     = (state != ST_FULL);
        avail     = (state != ST_EMPTY);
        push      = push_req && ready;
        pop       = pop_req && avail;
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (push) state_nxt = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (push && !pop && count == CW'(DEPTH - 1))
                    state_nxt = ST_FULL;
                else if (pop && !push && count == CW'(1))
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop) state_nxt = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_empty_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (count == '0));
    assert_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (count == CW'(DEPTH)));
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_hold_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count));
    assert_full_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && pop_req) |=> ready);
endmodule

// File: rtl/lrq_check.sv
module lrq_check #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [AW-1:0] calc_addr,
    input  logic [AW-1:0] stored_addr,
    output logic          mismatch,
    output logic          fault
);
    always_comb mismatch = pop && (calc_addr != stored_addr);

    always_ff @(posedge clk) begin
        if (!rst_n)        fault <= 1'b0;
        else if (mismatch) fault <= 1'b1;
    end

    assert_fault_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> fault);
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |-> !mismatch);
endmodule

// File: rtl/load_replay_queue.sv
module load_replay_queue #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead_valid,
    input  logic [AW-1:0] lead_addr,
    input  logic [DW-1:0] lead_data,
    output logic          lead_ready,
    input  logic          trail_valid,
    input  logic [AW-1:0] trail_addr,
    output logic          trail_avail,
    output logic [DW-1:0] trail_data,
    output logic          trail_mismatch,
    output logic          fault_flag
);
    logic          push, pop;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] head_addr;

    lrq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_req(lead_valid), .pop_req(trail_valid),
        .ready(lead_ready), .avail(trail_avail),
        .push(push), .pop(pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    lrq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk(clk), .wr_en(push), .wr_ptr(wr_ptr),
        .wr_addr(lead_addr), .wr_data(lead_data),
        .rd_ptr(rd_ptr), .rd_addr(head_addr), .rd_data(trail_data)
    );

    lrq_check #(.AW(AW)) u_check (
        .clk(clk), .rst_n(rst_n), .pop(pop),
        .calc_addr(trail_addr), .stored_addr(head_addr),
        .mismatch(trail_mismatch), .fault(fault_flag)
    );

    assert_stall_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !trail_avail |-> !trail_mismatch);
endmodule

// File: tb/load_replay_queue_tb.sv
module load_replay_queue_tb;
    localparam int D  = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lead_valid = 1'b0;
    logic [AW-1:0] lead_addr = '0;
    logic [DW-1:0] lead_data = '0;
    logic          lead_ready;
    logic          trail_valid = 1'b0;
    logic [AW-1:0] trail_addr = '0;
    logic          trail_avail;
    logic [DW-1:0] trail_data;
    logic          trail_mismatch;
    logic          fault_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int qa [D];
    int qd [D];
    int head = 0;
    int cnt  = 0;
    int seq  = 0;
    bit mfault = 1'b0;
    string ready_tag = "R1";

    always #5 clk = ~clk;

    load_replay_queue #(.DEPTH(D), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_data(lead_data),
        .lead_ready(lead_ready),
        .trail_valid(trail_valid), .trail_addr(trail_addr),
        .trail_avail(trail_avail), .trail_data(trail_data),
        .trail_mismatch(trail_mismatch), .fault_flag(fault_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check, then advance the model
    task automatic step(input bit lv, input bit tv, input bit bad);
        bit e_ready, e_avail, e_mis, pushed, popped;
        int tail;
        @(negedge clk);
        lead_valid  = lv;
        lead_addr   = AW'(seq * 7 + 3);
        lead_data   = DW'(seq * 37 + 1);
        trail_valid = tv;
        trail_addr  = (cnt > 0) ? AW'(qa[head] ^ (bad ? 1 : 0)) : AW'(8'h5A);
        #1;
        e_ready = (cnt < D);
        e_avail = (cnt > 0);
        e_mis   = tv && e_avail && bad;
        chk(lead_ready == e_ready, (cnt == D) ? "R5" : ready_tag, lead_ready, e_ready);
        chk(trail_avail == e_avail, "R4", trail_avail, e_avail);
        if (e_avail) chk(trail_data == DW'(qd[head]), "R3", trail_data, qd[head] % 65536);
        chk(trail_mismatch == e_mis, bad ? "R7" : "R8", trail_mismatch, e_mis);
        chk(fault_flag == mfault, "R7", fault_flag, mfault);
        @(posedge clk);
        pushed = lv && e_ready;
        popped = tv && e_avail;
        ready_tag = "R2";
        if (pushed && popped) ready_tag = "R6";
        if (popped && cnt == D) ready_tag = "R9";
        tail = (head + cnt) % D;
        if (popped) head = (head + 1) % D;
        if (pushed) begin
            qa[tail] = (seq * 7 + 3) % 256;
            qd[tail] = (seq * 37 + 1) % 65536;
            seq++;
        end
        cnt = cnt + (pushed ? 1 : 0) - (popped ? 1 : 0);
        if (e_mis) mfault = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lead_valid = 1'b0;
        trail_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        head = 0; cnt = 0; mfault = 1'b0; ready_tag = "R1";
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1: reset state, with a stalled trailing request (R4)
        step(1'b0, 1'b1, 1'b0);
        // R5: fill beyond capacity; extra commits must be dropped
        for (int i = 0; i < D + 3; i++) step(1'b1, 1'b0, 1'b0);
        // R9 / R3: drain in order, then a stalled read on empty (R4)
        for (int i = 0; i < D + 2; i++) step(1'b0, 1'b1, 1'b0);
        // R2, R3, R6: every 4-cycle pattern of push/pop requests
        for (int p = 0; p < 256; p++) begin
            for (int c = 0; c < 4; c++) step(p[2*c], p[2*c+1], 1'b0);
        end
        // R7: mismatch sets a sticky fault
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        // R1: reset clears the fault and the queue
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule